// File: doc/BRIEF.md
# Request/Reply Packet Link Endpoint

This endpoint sits at one end of a point-to-point memory request/response link that carries fixed 38-bit packets. Each packet has a 2-bit type, a 32-bit address or data word and a 4-bit CRC. On the send side, a local client hands the block a type and a word. The block appends the CRC and presents the finished packet on a valid/ready output. On the receive side, every incoming packet has its CRC recomputed. A corrupted packet is discarded and reported with a single-cycle error pulse. A good packet is decoded by its type.

The block answers on its own. A good request is acknowledged with the requested address echoed. On the next transmit opportunity after that, a reply follows, carrying the word read from a 16-entry local register array. A good reply is handed to the local client and acknowledged. Automatic answers take precedence over client traffic. While answers are outstanding, the block holds off both new client packets and new incoming packets.

Top module: `pkt_link_endpoint`

## Requirements
- R1: Every transmitted packet is laid out as bits [37:36] type, [35:4] word, [3:0] CRC. The CRC is CRC-4 with polynomial x^4+x+1 and initial value 0000, computed over bits [37:4] most significant bit first. A client packet accepted on `tx_req_valid && tx_req_ready` appears on `tx_pkt` one cycle later with its type and word unchanged.
- R2: While `tx_pkt_valid` is high and `tx_pkt_ready` is low, `tx_pkt_valid` stays high and `tx_pkt` stays unchanged.
- R3: A packet accepted with a CRC mismatch raises `crc_error` for exactly the one cycle after acceptance. It produces no transmitted packet and no `rx_reply_valid`.
- R4: A packet accepted with good CRC and type 00 (request) causes a type 10 packet whose word echoes the full received address. On the next transmit opportunity after that comes a type 01 packet whose word is the register array entry at the address.
- R5: Only address bits [3:0] select the register entry. Bits [31:4] do not change which entry is returned.
- R6: A good packet of type 01 (reply) raises `rx_reply_valid` for one cycle with `rx_reply_data` equal to its word, and causes a type 11 packet echoing that word.
- R7: Good packets of type 10 or 11 (acknowledgements) produce no transmitted packet, no `crc_error` and no `rx_reply_valid`.
- R8: Pending automatic packets are sent before any client packet. While any are pending, `tx_req_ready` and `rx_pkt_ready` are low.
- R9: After reset, `tx_pkt_valid`, `crc_error` and `rx_reply_valid` are low and `rx_reply_data` is zero. With an idle link, `tx_req_ready` and `rx_pkt_ready` are high.
- R10: A cycle with `reg_wr_en` high stores `reg_wr_data` into entry `reg_wr_addr`, and later requests to that entry return it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_req_valid | input | 1 | Client packet offered |
| tx_req_ready | output | 1 | Client packet taken this cycle |
| tx_req_type | input | 2 | Client packet type |
| tx_req_word | input | 32 | Client address or data word |
| tx_pkt_valid | output | 1 | Outgoing packet present |
| tx_pkt_ready | input | 1 | Link takes the outgoing packet |
| tx_pkt | output | 38 | Outgoing packet |
| rx_pkt_valid | input | 1 | Incoming packet present |
| rx_pkt_ready | output | 1 | Endpoint takes the incoming packet |
| rx_pkt | input | 38 | Incoming packet |
| crc_error | output | 1 | One-cycle pulse for a dropped, corrupted packet |
| rx_reply_valid | output | 1 | One-cycle pulse for a good received reply |
| rx_reply_data | output | 32 | Word of the last good received reply |
| reg_wr_en | input | 1 | Register array write strobe |
| reg_wr_addr | input | 4 | Register array write index |
| reg_wr_data | input | 32 | Register array write data |

## Verification
On every cycle, the assertions check four things. The CRC field of any presented packet must agree with its body. A stalled packet must hold. Each error pulse must follow an accepted packet and never coincide with a reply pulse. Client acceptance must never happen while incoming traffic is blocked. Some behaviours only the directed scenarios can show. These are the exact ordering of acknowledge, reply and client packet under stalls, the echoed addresses, and the returned register contents. They also cover the folding of upper address bits and the silence that follows dropped or acknowledgement packets.

// File: rtl/plink_pkg.sv
package plink_pkg;
  localparam int TYPE_W = 2;
  localparam int WORD_W = 32;
  localparam int CRC_W  = 4;
  localparam int BODY_W = TYPE_W + WORD_W;
  localparam int PKT_W  = BODY_W + CRC_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 4'b0011;

  typedef enum logic [TYPE_W-1:0] {
    PT_REQ     = 2'b00,
    PT_REP     = 2'b01,
    PT_REQ_ACK = 2'b10,
    PT_REP_ACK = 2'b11
  } ptype_e;

  // bit-serial reference form, used by the checker
  function automatic logic [CRC_W-1:0] crc4_ref(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ body[i];
      r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return r;
  endfunction
endpackage

// File: rtl/plink_crc4.sv
module plink_crc4 #(
  parameter int DATA_W = 34,
  parameter int CRC_W  = 4,
  parameter logic [CRC_W-1:0] POLY = 4'b0011
) (
  input  logic [DATA_W-1:0] data,
  output logic [CRC_W-1:0]  crc
);
  logic [CRC_W-1:0] chain [0:DATA_W];
  assign chain[0] = '0;

  for (genvar g = 0; g < DATA_W; g++) begin : g_step
    logic fb;
    assign fb = chain[g][CRC_W-1] ^ data[DATA_W-1-g];
    assign chain[g+1] = {chain[g][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign crc = chain[DATA_W];
endmodule

// File: rtl/plink_regfile.sv
module plink_regfile #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/plink_tx_stage.sv
module plink_tx_stage
  import plink_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ack_pend,
  input  logic [TYPE_W-1:0] ack_type,
  input  logic [WORD_W-1:0] ack_word,
  input  logic              rep_pend,
  input  logic [WORD_W-1:0] rep_word,
  input  logic              usr_valid,
  input  logic [TYPE_W-1:0] usr_type,
  input  logic [WORD_W-1:0] usr_word,
  output logic              usr_ready,
  output logic              take_ack,
  output logic              take_rep,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [PKT_W-1:0]  out_pkt
);
  logic              load_ok;
  logic [TYPE_W-1:0] sel_type;
  logic [WORD_W-1:0] sel_word;
  logic [CRC_W-1:0]  sel_crc;
  logic              any_src;

  assign load_ok   = !out_valid || out_ready;
  assign take_ack  = load_ok && ack_pend;
  assign take_rep  = load_ok && !ack_pend && rep_pend;
  assign usr_ready = load_ok && !ack_pend && !rep_pend;
  assign any_src   = ack_pend || rep_pend || usr_valid;

  always_comb begin
    if (ack_pend) begin
      sel_type = ack_type;
      sel_word = ack_word;
    end else if (rep_pend) begin
      sel_type = PT_REP;
      sel_word = rep_word;
    end else begin
      sel_type = usr_type;
      sel_word = usr_word;
    end
  end

  plink_crc4 #(.DATA_W(BODY_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_tx_crc (
    .data ({sel_type, sel_word}),
    .crc  (sel_crc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pkt   <= '0;
    end else if (load_ok) begin
      out_valid <= any_src;
      if (any_src) out_pkt <= {sel_type, sel_word, sel_crc};
    end
  end
endmodule

// File: rtl/pkt_link_endpoint.sv
module pkt_link_endpoint
  import plink_pkg::*;
#(
  parameter int REG_DEPTH = 16,
  localparam int REG_AW   = $clog2(REG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_req_valid,
  output logic              tx_req_ready,
  input  logic [TYPE_W-1:0] tx_req_type,
  input  logic [WORD_W-1:0] tx_req_word,
  output logic              tx_pkt_valid,
  input  logic              tx_pkt_ready,
  output logic [PKT_W-1:0]  tx_pkt,
  input  logic              rx_pkt_valid,
  output logic              rx_pkt_ready,
  input  logic [PKT_W-1:0]  rx_pkt,
  output logic              crc_error,
  output logic              rx_reply_valid,
  output logic [WORD_W-1:0] rx_reply_data,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_wr_addr,
  input  logic [WORD_W-1:0] reg_wr_data
);
  logic              ack_pend, rep_pend;
  logic [TYPE_W-1:0] ack_type;
  logic [WORD_W-1:0] ack_word;
  logic [WORD_W-1:0] rd_word;
  logic              take_ack, take_rep;

  logic [TYPE_W-1:0] rx_type;
  logic [WORD_W-1:0] rx_word;
  logic [CRC_W-1:0]  rx_crc_calc;
  logic              rx_fire, crc_ok, got_req, got_rep;

  assign rx_type = rx_pkt[PKT_W-1 -: TYPE_W];
  assign rx_word = rx_pkt[CRC_W +: WORD_W];

  plink_crc4 #(.DATA_W(BODY_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_rx_crc (
    .data (rx_pkt[PKT_W-1:CRC_W]),
    .crc  (rx_crc_calc)
  );

  assign rx_pkt_ready = !ack_pend && !rep_pend;
  assign rx_fire      = rx_pkt_valid && rx_pkt_ready;
  assign crc_ok       = (rx_crc_calc == rx_pkt[CRC_W-1:0]);
  assign got_req      = rx_fire && crc_ok && (rx_type == PT_REQ);
  assign got_rep      = rx_fire && crc_ok && (rx_type == PT_REP);

  plink_regfile #(.DEPTH(REG_DEPTH), .DW(WORD_W)) u_regs (
    .clk   (clk),
    .we    (reg_wr_en),
    .waddr (reg_wr_addr),
    .wdata (reg_wr_data),
    .re    (got_req),
    .raddr (rx_word[REG_AW-1:0]),
    .rdata (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_pend       <= 1'b0;
      rep_pend       <= 1'b0;
      ack_type       <= '0;
      ack_word       <= '0;
      crc_error      <= 1'b0;
      rx_reply_valid <= 1'b0;
      rx_reply_data  <= '0;
    end else begin
      crc_error      <= rx_fire && !crc_ok;
      rx_reply_valid <= got_rep;
      if (got_rep) rx_reply_data <= rx_word;
      if (take_ack) ack_pend <= 1'b0;
      if (take_rep) rep_pend <= 1'b0;
      if (got_req) begin
        ack_pend <= 1'b1;
        rep_pend <= 1'b1;
        ack_type <= PT_REQ_ACK;
        ack_word <= rx_word;
      end else if (got_rep) begin
        ack_pend <= 1'b1;
        ack_type <= PT_REP_ACK;
        ack_word <= rx_word;
      end
    end
  end

  plink_tx_stage u_tx (
    .clk       (clk),
    .rst       (rst),
    .ack_pend  (ack_pend),
    .ack_type  (ack_type),
    .ack_word  (ack_word),
    .rep_pend  (rep_pend),
    .rep_word  (rd_word),
    .usr_valid (tx_req_valid),
    .usr_type  (tx_req_type),
    .usr_word  (tx_req_word),
    .usr_ready (tx_req_ready),
    .take_ack  (take_ack),
    .take_rep  (take_rep),
    .out_ready (tx_pkt_ready),
    .out_valid (tx_pkt_valid),
    .out_pkt   (tx_pkt)
  );
endmodule

// File: rtl/plink_checker.sv
module plink_checker
  import plink_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             tx_pkt_valid,
  input logic             tx_pkt_ready,
  input logic [PKT_W-1:0] tx_pkt,
  input logic             tx_req_ready,
  input logic             rx_pkt_valid,
  input logic             rx_pkt_ready,
  input logic             crc_error,
  input logic             rx_reply_valid
);
  assert_crc_field_R1: assert property (@(posedge clk) disable iff (rst)
    tx_pkt_valid |-> tx_pkt[CRC_W-1:0] == crc4_ref(tx_pkt[PKT_W-1:CRC_W]));

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_pkt_valid && !tx_pkt_ready) |=> (tx_pkt_valid && $stable(tx_pkt)));

  assert_err_source_R3: assert property (@(posedge clk) disable iff (rst)
    crc_error |-> $past(rx_pkt_valid && rx_pkt_ready));

  assert_err_excl_R3: assert property (@(posedge clk) disable iff (rst)
    !(crc_error && rx_reply_valid));

  assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
    tx_req_ready |-> rx_pkt_ready);

  assert_reset_R9: assert property (@(posedge clk)
    $past(rst) |-> (!tx_pkt_valid && !crc_error && !rx_reply_valid));
endmodule

bind pkt_link_endpoint plink_checker u_plink_checker (
  .clk            (clk),
  .rst            (rst),
  .tx_pkt_valid   (tx_pkt_valid),
  .tx_pkt_ready   (tx_pkt_ready),
  .tx_pkt         (tx_pkt),
  .tx_req_ready   (tx_req_ready),
  .rx_pkt_valid   (rx_pkt_valid),
  .rx_pkt_ready   (rx_pkt_ready),
  .crc_error      (crc_error),
  .rx_reply_valid (rx_reply_valid)
);

// File: tb/pkt_link_endpoint_bench.sv
module pkt_link_endpoint_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_req_valid = 1'b0;
  logic        tx_req_ready;
  logic [1:0]  tx_req_type = '0;
  logic [31:0] tx_req_word = '0;
  logic        tx_pkt_valid;
  logic        tx_pkt_ready = 1'b1;
  logic [37:0] tx_pkt;
  logic        rx_pkt_valid = 1'b0;
  logic        rx_pkt_ready;
  logic [37:0] rx_pkt = '0;
  logic        crc_error;
  logic        rx_reply_valid;
  logic [31:0] rx_reply_data;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pkt_link_endpoint u_pkt_link_endpoint (.*);

  function automatic logic [3:0] tb_crc(input logic [33:0] b);
    logic [3:0] c = 4'b0000;
    for (int i = 33; i >= 0; i--) begin
      if (c[3] ^ b[i]) c = {c[2:0], 1'b0} ^ 4'b0011;
      else             c = {c[2:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [37:0] mk(input logic [1:0] t, input logic [31:0] w);
    return {t, w, tb_crc({t, w})};
  endfunction

  function automatic logic [31:0] regval(input int i);
    return 32'hA500_0000 + i * 32'h0001_1111;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_rx(input logic [37:0] p);
    @(negedge clk);
    rx_pkt = p;
    rx_pkt_valid = 1'b1;
    #1;
    while (!rx_pkt_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    rx_pkt_valid = 1'b0;
  endtask

  task automatic send_usr(input logic [1:0] t, input logic [31:0] w);
    @(negedge clk);
    tx_req_type = t;
    tx_req_word = w;
    tx_req_valid = 1'b1;
    #1;
    while (!tx_req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    tx_req_valid = 1'b0;
  endtask

  task automatic collect(output logic [37:0] p, output bit got);
    got = 0;
    p = '0;
    for (int i = 0; i < 20; i++) begin
      if (tx_pkt_valid) begin
        p = tx_pkt;
        got = 1;
        @(negedge clk);
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_pkt(input logic [37:0] exp, input string req);
    logic [37:0] p;
    bit got;
    collect(p, got);
    check(got && p == exp, req, {26'd0, p}, {26'd0, exp});
  endtask

  task automatic expect_quiet(input string req);
    bit seen = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (tx_pkt_valid || crc_error || rx_reply_valid) seen = 1;
    end
    check(!seen, req, {63'd0, seen}, 64'd0);
  endtask

  task automatic t_reset;
    check(!tx_pkt_valid && !crc_error && !rx_reply_valid, "R9 outputs idle",
          {61'd0, tx_pkt_valid, crc_error, rx_reply_valid}, 64'd0);
    check(rx_reply_data == 32'd0, "R9 reply data", {32'd0, rx_reply_data}, 64'd0);
    check(tx_req_ready && rx_pkt_ready, "R9 ready", {62'd0, tx_req_ready, rx_pkt_ready}, 64'd3);
  endtask

  task automatic t_load_regs;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      reg_wr_en = 1'b1;
      reg_wr_addr = 4'(i);
      reg_wr_data = regval(i);
    end
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic t_user_tx;
    send_usr(2'b00, 32'h1234_5678);
    expect_pkt(mk(2'b00, 32'h1234_5678), "R1 client type 00");
    send_usr(2'b11, 32'hFFFF_FFFF);
    expect_pkt(mk(2'b11, 32'hFFFF_FFFF), "R1 client type 11");
    send_usr(2'b01, 32'h0000_0000);
    expect_pkt(mk(2'b01, 32'h0000_0000), "R1 client zero word");
  endtask

  task automatic t_stall;
    logic [37:0] e;
    e = mk(2'b10, 32'hDEAD_BEEF);
    tx_pkt_ready = 1'b0;
    send_usr(2'b10, 32'hDEAD_BEEF);
    for (int i = 0; i < 4; i++) begin
      check(tx_pkt_valid && tx_pkt == e, "R2 held under stall", {26'd0, tx_pkt}, {26'd0, e});
      @(negedge clk);
    end
    tx_pkt_ready = 1'b1;
    expect_pkt(e, "R2 released");
  endtask

  task automatic t_request;
    send_rx(mk(2'b00, 32'h0000_0005));
    check(!rx_pkt_ready && !tx_req_ready, "R8 busy while pending",
          {62'd0, rx_pkt_ready, tx_req_ready}, 64'd0);
    expect_pkt(mk(2'b10, 32'h0000_0005), "R4 request ack");
    expect_pkt(mk(2'b01, regval(5)), "R4 reply data");
  endtask

  task automatic t_upper_bits;
    send_rx(mk(2'b00, 32'hFFFF_FFF3));
    expect_pkt(mk(2'b10, 32'hFFFF_FFF3), "R5 ack echoes full address");
    expect_pkt(mk(2'b01, regval(3)), "R5 upper bits ignored");
  endtask

  task automatic t_rewrite;
    @(negedge clk);
    reg_wr_en = 1'b1;
    reg_wr_addr = 4'd5;
    reg_wr_data = 32'h0BAD_F00D;
    @(negedge clk);
    reg_wr_en = 1'b0;
    send_rx(mk(2'b00, 32'h0000_0005));
    expect_pkt(mk(2'b10, 32'h0000_0005), "R10 ack");
    expect_pkt(mk(2'b01, 32'h0BAD_F00D), "R10 rewritten entry");
  endtask

  task automatic t_bad_crc;
    logic [37:0] p;
    p = mk(2'b00, 32'h0000_0002) ^ 38'h1;
    send_rx(p);
    check(crc_error == 1'b1, "R3 error pulse", {63'd0, crc_error}, 64'd1);
    @(negedge clk);
    check(crc_error == 1'b0, "R3 pulse one cycle", {63'd0, crc_error}, 64'd0);
    expect_quiet("R3 bad request silent");
    p = mk(2'b01, 32'h7777_0000) ^ (38'h1 << 20);
    send_rx(p);
    check(crc_error && !rx_reply_valid, "R3 bad reply dropped",
          {62'd0, crc_error, rx_reply_valid}, 64'd2);
    expect_quiet("R3 bad reply silent");
  endtask

  task automatic t_reply_rx;
    send_rx(mk(2'b01, 32'hCAFE_F00D));
    check(rx_reply_valid && rx_reply_data == 32'hCAFE_F00D, "R6 reply delivered",
          {31'd0, rx_reply_valid, rx_reply_data}, {31'd0, 1'b1, 32'hCAFE_F00D});
    expect_pkt(mk(2'b11, 32'hCAFE_F00D), "R6 reply ack");
    check(!rx_reply_valid, "R6 reply pulse one cycle", {63'd0, rx_reply_valid}, 64'd0);
  endtask

  task automatic t_acks_rx;
    send_rx(mk(2'b10, 32'h0000_0009));
    expect_quiet("R7 request ack ignored");
    send_rx(mk(2'b11, 32'h1111_2222));
    expect_quiet("R7 reply ack ignored");
    check(rx_reply_data == 32'hCAFE_F00D, "R7 reply data untouched",
          {32'd0, rx_reply_data}, {32'd0, 32'hCAFE_F00D});
  endtask

  task automatic t_priority;
    logic [37:0] ea, er, eu;
    ea = mk(2'b10, 32'h0000_0007);
    er = mk(2'b01, regval(7));
    eu = mk(2'b00, 32'h5555_AAAA);
    tx_pkt_ready = 1'b0;
    send_rx(mk(2'b00, 32'h0000_0007));
    tx_req_type = 2'b00;
    tx_req_word = 32'h5555_AAAA;
    tx_req_valid = 1'b1;
    #1;
    check(!tx_req_ready, "R8 client held off", {63'd0, tx_req_ready}, 64'd0);
    @(negedge clk);
    check(tx_pkt == ea, "R8 ack first", {26'd0, tx_pkt}, {26'd0, ea});
    tx_pkt_ready = 1'b1;
    @(negedge clk);
    tx_pkt_ready = 1'b0;
    check(tx_pkt_valid && tx_pkt == er, "R8 reply second", {26'd0, tx_pkt}, {26'd0, er});
    tx_pkt_ready = 1'b1;
    @(negedge clk);
    tx_req_valid = 1'b0;
    check(tx_pkt_valid && tx_pkt == eu, "R8 client last", {26'd0, tx_pkt}, {26'd0, eu});
    @(negedge clk);
    check(!tx_pkt_valid, "R8 drained", {63'd0, tx_pkt_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_load_regs();
    t_user_tx();
    t_stall();
    t_request();
    t_upper_bits();
    t_rewrite();
    t_bad_crc();
    t_reply_rx();
    t_acks_rx();
    t_priority();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule